// File: doc/BRIEF.md
# Storage Display View/Hold Controller

This block decides when the flood guns of a storage display are lit. It drives one output, `view_o`. It also raises an automatic erase request after the screen has sat idle in hold for a long time. It counts every duration in ticks of a slow timebase strobe (`tick_i`). Every duration is a parameter.

A shift-key event or a new-information-written event restarts a long view timer. While that timer runs, the block sits in state `S_VIEW` and `view_o` is held steadily high. When the timer runs out, the state machine moves from `S_VIEW` to `S_HOLD` (transition `EXPIRE`). In `S_HOLD` a low-duty square wave drives `view_o`. The wave is high for `HOLD_HIGH` ticks out of every `HOLD_PERIOD` ticks, by default 123 out of 1000. The stored image is kept while the screen stays mostly dark. Any activity moves the machine from `S_HOLD` back to `S_VIEW` (transition `WAKE`). Activity in `S_VIEW` reloads the timer (transition `RELOAD`).

A hold-duration counter runs in `S_HOLD`. After `ERASE_TICKS` ticks without activity it emits a one-cycle erase request, then starts counting again. While the hard-copy busy flag is high, `view_o` is forced high and the hold-duration count is frozen, so no erase is requested during a copy.

Top module: `vh_view_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, the block is in `S_VIEW` with the view timer loaded to `VIEW_TICKS`, `view_o` is 1 and `erase_req_o` is 0.
- R2: A strobe on `shift_evt_i` or `write_evt_i`, in any cycle and with or without a tick, reloads the view timer. `view_o` is then 1 on every cycle until `VIEW_TICKS` further ticks have passed.
- R3: On the tick that empties the view timer, the state moves to `S_HOLD`. From that edge on, `view_o` is 1 for the first `HOLD_HIGH` ticks of each `HOLD_PERIOD`-tick period and 0 for the rest, starting with the high part.
- R4: After `ERASE_TICKS` counted ticks in `S_HOLD` with no activity, `erase_req_o` is 1 for exactly one clock cycle, in the cycle after the counting edge. The count then restarts from zero, so requests repeat every `ERASE_TICKS` ticks.
- R5: While `copy_busy_i` is 1, `view_o` is 1 in the same cycle, whatever the state.
- R6: While `copy_busy_i` is 1, ticks do not advance the hold-duration count, so no erase request is raised.
- R7: Activity in `S_HOLD` returns the block to `S_VIEW`. It clears the hold-duration count and restarts the oscillator phase at the start of its high part.
- R8: Cycles without `tick_i` and without activity change neither the state nor any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe; one tick per pulse |
| shift_evt_i | input | 1 | Single-cycle strobe: shift key closed |
| write_evt_i | input | 1 | Single-cycle strobe: new item written to screen |
| copy_busy_i | input | 1 | Hard-copy busy level |
| view_o | output | 1 | Flood guns on |
| erase_req_o | output | 1 | One-cycle automatic erase request |

## Verification
The assertions check the following on every cycle:
- an erase request lasts exactly one cycle and never follows an activity cycle;
- `view_o` is high whenever the busy flag is high or the machine is in `S_VIEW`;
- activity always lands in `S_VIEW`;
- the state and the oscillator phase hold still across cycles with neither a tick nor activity.

Only the bench's scenarios can show the timing that depends on counts: the exact length of the view window, the number of high ticks per oscillator period, the spacing of erase requests, and the freeze of the erase count during a copy.

// File: rtl/vh_pkg.sv
package vh_pkg;
    typedef enum logic {
        S_VIEW = 1'b0,
        S_HOLD = 1'b1
    } vh_state_t;
endpackage

// File: rtl/vh_view_timer.sv
module vh_view_timer #(
    parameter int unsigned VIEW_TICKS = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);
    localparam int unsigned W = $clog2(VIEW_TICKS + 1);
    localparam logic [W-1:0] LOAD_V = W'(VIEW_TICKS);
    localparam logic [W-1:0] ONE_V  = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i)
            cnt_q <= LOAD_V;
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - ONE_V;
    end

    assign last_o = (cnt_q == ONE_V);
endmodule

// File: rtl/vh_hold_osc.sv
module vh_hold_osc #(
    parameter int unsigned HOLD_PERIOD = 1000,
    parameter int unsigned HOLD_HIGH   = 123
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic adv_i,
    output logic high_o
);
    localparam int unsigned W = $clog2(HOLD_PERIOD);
    localparam logic [W-1:0] LAST_V = W'(HOLD_PERIOD - 1);
    localparam logic [W-1:0] HIGH_V = W'(HOLD_HIGH);
    localparam logic [W-1:0] ONE_V  = W'(1);

    logic [W-1:0] phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i)
            phase_q <= '0;
        else if (adv_i)
            phase_q <= (phase_q == LAST_V) ? '0 : phase_q + ONE_V;
    end

    assign high_o = (phase_q < HIGH_V);
endmodule

// File: rtl/vh_hold_watch.sv
module vh_hold_watch #(
    parameter int unsigned ERASE_TICKS = 18000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic adv_i,
    output logic fire_o
);
    localparam int unsigned W = $clog2(ERASE_TICKS + 1);
    localparam logic [W-1:0] LAST_V = W'(ERASE_TICKS - 1);
    localparam logic [W-1:0] ONE_V  = W'(1);

    logic [W-1:0] cnt_q;

    assign fire_o = adv_i && (cnt_q == LAST_V);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i || fire_o)
            cnt_q <= '0;
        else if (adv_i)
            cnt_q <= cnt_q + ONE_V;
    end
endmodule

// File: rtl/vh_view_ctrl.sv
module vh_view_ctrl
    import vh_pkg::*;
#(
    parameter int unsigned VIEW_TICKS  = 1000,
    parameter int unsigned HOLD_PERIOD = 1000,
    parameter int unsigned HOLD_HIGH   = 123,
    parameter int unsigned ERASE_TICKS = 18000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic shift_evt_i,
    input  logic write_evt_i,
    input  logic copy_busy_i,
    output logic view_o,
    output logic erase_req_o
);
    vh_state_t state_q, state_d;
    logic act, timer_last, osc_high, watch_fire, erase_q;
    logic in_view, in_hold;

    assign act     = shift_evt_i | write_evt_i;
    assign in_view = (state_q == S_VIEW);
    assign in_hold = (state_q == S_HOLD);

    vh_view_timer #(.VIEW_TICKS(VIEW_TICKS)) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (act),
        .dec_i  (in_view && tick_i),
        .last_o (timer_last)
    );

    vh_hold_osc #(.HOLD_PERIOD(HOLD_PERIOD), .HOLD_HIGH(HOLD_HIGH)) u_osc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (act || in_view),
        .adv_i   (in_hold && tick_i),
        .high_o  (osc_high)
    );

    vh_hold_watch #(.ERASE_TICKS(ERASE_TICKS)) u_watch (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (act || in_view),
        .adv_i   (in_hold && tick_i && !copy_busy_i && !act),
        .fire_o  (watch_fire)
    );

    // next-state: RELOAD / WAKE on activity, EXPIRE on the last view tick
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_VIEW: if (!act && tick_i && timer_last) state_d = S_HOLD;
            S_HOLD: if (act) state_d = S_VIEW;
            default: state_d = S_VIEW;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= S_VIEW;
            erase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            erase_q <= watch_fire;
        end
    end

    always_comb begin
        view_o      = 1'b1;
        erase_req_o = erase_q;
        unique case (state_q)
            S_VIEW: view_o = 1'b1;
            S_HOLD: view_o = copy_busy_i | osc_high;
            default: view_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/vh_view_chk.sv
module vh_view_chk
    import vh_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      tick_i,
    input  logic      shift_evt_i,
    input  logic      write_evt_i,
    input  logic      copy_busy_i,
    input  logic      view_o,
    input  logic      erase_req_o,
    input  vh_state_t state_q,
    input  logic      osc_high
);
    logic act;
    assign act = shift_evt_i | write_evt_i;

    p_erase_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        erase_req_o |=> !erase_req_o);

    p_erase_no_act_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        act |=> !erase_req_o);

    p_busy_view_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        copy_busy_i |-> view_o);

    p_view_mode_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_VIEW) |-> view_o);

    p_act_wake_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        act |=> (state_q == S_VIEW));

    p_idle_state_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !act) |=> $stable(state_q));

    p_idle_osc_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !act && state_q == S_HOLD) |=> $stable(osc_high));

    p_reset_r1: assert property (@(posedge clk_i)
        rst_i |=> (state_q == S_VIEW && !erase_req_o));
endmodule

bind vh_view_ctrl vh_view_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick_i),
    .shift_evt_i (shift_evt_i),
    .write_evt_i (write_evt_i),
    .copy_busy_i (copy_busy_i),
    .view_o      (view_o),
    .erase_req_o (erase_req_o),
    .state_q     (state_q),
    .osc_high    (osc_high)
);

// File: tb/sim_vh_view_ctrl.sv
module sim_vh_view_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int VT = 20;
    localparam int P  = 10;
    localparam int H  = 3;
    localparam int E  = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, sh = 1'b0, wr = 1'b0, busy = 1'b0;
    logic view, erase;
    int checks = 0, fails = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vh_view_ctrl #(.VIEW_TICKS(VT), .HOLD_PERIOD(P), .HOLD_HIGH(H), .ERASE_TICKS(E)) u0 (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .shift_evt_i(sh),
        .write_evt_i(wr), .copy_busy_i(busy), .view_o(view), .erase_req_o(erase)
    );

    // reference model state (bench only)
    bit m_hold; int m_vc, m_ph, m_hc; bit m_er;

    function automatic bit exp_view(bit hold, int ph, bit b);
        return b || !hold || (ph < H);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hold <= 0; m_vc <= VT; m_ph <= 0; m_hc <= 0; m_er <= 0;
        end else begin
            m_er <= m_hold && tick && !busy && !(sh|wr) && (m_hc == E-1);
            if (sh | wr) begin
                m_hold <= 0; m_vc <= VT; m_ph <= 0; m_hc <= 0;
            end else if (!m_hold) begin
                if (tick) begin
                    if (m_vc == 1) begin m_hold <= 1; m_ph <= 0; m_hc <= 0; end
                    else m_vc <= m_vc - 1;
                end
            end else if (tick) begin
                m_ph <= (m_ph == P-1) ? 0 : m_ph + 1;
                if (!busy) m_hc <= (m_hc == E-1) ? 0 : m_hc + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, sampled mid-cycle
    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk(view == exp_view(m_hold, m_ph, busy), "R3/R5 view", view,
                exp_view(m_hold, m_ph, busy));
            chk(erase == m_er, "R4/R6 erase", erase, m_er);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int highs, pulses;
        bit prev;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(view == 1, "R1 view in reset", view, 1);
        chk(erase == 0, "R1 erase in reset", erase, 0);
        rst = 0; tick = 1;
        model_on = 1;
        // directed: idle with a tick every cycle
        highs = 0; pulses = 0; prev = 0;
        for (int k = 1; k <= 130; k++) begin
            @(posedge clk); @(negedge clk);
            if (k < VT) chk(view == 1, "R2 view window", view, 1);
            if (k >= VT && k < VT + P && view) highs++;
            if (erase) begin
                pulses++;
                chk(prev == 0, "R4 single-cycle pulse", 1, 0);
            end
            prev = erase;
        end
        chk(highs == H, "R3 highs per period", highs, H);
        chk(pulses == 2, "R4 erase spacing", pulses, 2);
        // busy during hold: view forced, no erase
        busy = 1; pulses = 0; highs = 0;
        for (int k = 0; k < 120; k++) begin
            @(posedge clk); @(negedge clk);
            if (view) highs++;
            if (erase) pulses++;
        end
        chk(highs == 120, "R5 busy forces view", highs, 120);
        chk(pulses == 0, "R6 no erase while busy", pulses, 0);
        busy = 0;
        // no ticks: nothing changes
        tick = 0; pulses = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); @(negedge clk);
            if (erase) pulses++;
        end
        chk(pulses == 0, "R8 no erase without ticks", pulses, 0);
        // wake from hold without tick
        wr = 1; @(posedge clk); @(negedge clk); wr = 0;
        chk(view == 1, "R7 wake view", view, 1);
        tick = 1; highs = 0;
        for (int k = 0; k < VT - 1; k++) begin
            @(posedge clk); @(negedge clk);
            if (view) highs++;
        end
        chk(highs == VT - 1, "R2 window after wake", highs, VT - 1);
        // random phase
        for (int k = 0; k < 30000; k++) begin
            tick = ($urandom_range(0, 1) == 1);
            sh   = ($urandom_range(0, 299) == 0);
            wr   = ($urandom_range(0, 299) == 0);
            if ($urandom_range(0, 199) == 0) busy = !busy;
            @(posedge clk); @(negedge clk);
        end
        sh = 0; wr = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule